// File: doc/BRIEF.md
# Threshold-Driven Transmit/Receive FIFO Pair

This block sits between a DMA engine and a serial line engine and holds two independent byte queues sharing one clock. The transmit queue is filled from the DMA side and drained by the serial side. The receive queue is filled by the serial side and drained by the DMA side. Each queue raises its own DMA request from its fill level compared against a request level. The request level is either programmed through a configuration input or, in a compatibility mode, fixed at 16 bytes. In that mode each queue's usable capacity shrinks from 96 to 32 bytes.

The transmit queue keeps every byte it has handed to the serial side since the current frame began. On a collision it moves its read position back to the first byte of the frame, so the frame is sent again without new DMA fetches. If new writes have had to reuse the storage of already-sent bytes, a replay is no longer possible and the collision is answered with a one-cycle failure pulse. An optional delayed start holds off the serial side until the transmit level reaches the request level. Reads and writes that cannot be served set sticky error flags.

Top module: `dual_lane_fifo`

## Requirements
- R1: Usable capacity is 96 bytes per queue with `compat_mode`=0 and 32 bytes with `compat_mode`=1. A write when the count equals or exceeds the capacity is dropped, leaves the count unchanged and sets the queue's sticky overflow flag. Only reset clears the flag.
- R2: The request level is 16 with `compat_mode`=1 and `level_cfg` otherwise.
- R3: `tx_dreq` is 1 exactly while `tx_count` is below the request level.
- R4: `rx_dreq` is 1 while `rx_count` is at or above the request level, or while an end of frame is pending. A pulse on `rx_eof` makes an end of frame pending. It stays pending until the receive count returns to zero.
- R5: `tx_start_ok` is 1 when `delay_start`=1 and `tx_count` is at or above the request level, or when `delay_start`=0 and `tx_count` is at least 1.
- R6: Both queues are first-in first-out. `tx_rdata` and `rx_rdata` show the oldest unread byte whenever the matching count is nonzero, and a read advances to the next byte in the following cycle.
- R7: A read from an empty queue has no effect on count or data and sets that queue's sticky underrun flag. A transmit read in a cycle with `tx_collision`=1 is ignored and raises no flag.
- R8: `tx_collision` with replay possible moves the transmit read position back to the first byte sent since the last `tx_frame_end`. The count grows by the number of such bytes, and they are read out again in their original order.
- R9: `tx_frame_end` discards the record of sent bytes. A later collision then replays nothing and leaves count and data unchanged. It also clears the replay-lost state.
- R10: An accepted transmit write is an overwrite when the count plus the sent-byte record is at or above capacity. It drops the oldest sent byte and marks replay as lost. A collision while replay is lost, or in the same cycle as an overwrite, changes nothing and makes `tx_rewind_fail` 1 for exactly the next cycle.
- R11: After reset both counts are 0, all flags and `tx_rewind_fail` are 0, and `rx_dreq` is 0 with a nonzero request level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| compat_mode | input | 1 | Compatibility mode: 32-byte capacity, level 16 |
| level_cfg | input | 7 | Programmed request level |
| delay_start | input | 1 | Hold transmit start until the request level is reached |
| tx_wr | input | 1 | DMA-side transmit write |
| tx_wdata | input | 8 | Transmit write byte |
| tx_rd | input | 1 | Serial-side transmit read |
| tx_collision | input | 1 | Collision: replay the current frame |
| tx_frame_end | input | 1 | Current transmit frame finished |
| tx_rdata | output | 8 | Oldest unread transmit byte |
| tx_count | output | 7 | Unread transmit bytes |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_start_ok | output | 1 | Transmission may start |
| tx_overflow | output | 1 | Sticky transmit overflow |
| tx_underrun | output | 1 | Sticky transmit underrun |
| tx_rewind_fail | output | 1 | Replay impossible, one-cycle pulse |
| rx_wr | input | 1 | Serial-side receive write |
| rx_wdata | input | 8 | Receive write byte |
| rx_eof | input | 1 | End of received frame |
| rx_rd | input | 1 | DMA-side receive read |
| rx_rdata | output | 8 | Oldest unread receive byte |
| rx_count | output | 7 | Unread receive bytes |
| rx_dreq | output | 1 | Receive DMA request |
| rx_overflow | output | 1 | Sticky receive overflow |
| rx_underrun | output | 1 | Sticky receive underrun |

## Verification
The hardest state to reach is a collision after new writes have reused the storage of bytes already sent in the current frame. Reaching it needs a fill, a partial drain and a refill, all without an intervening frame end. The stimulus gets there in compatibility mode, where the 32-byte limit is reached in a few dozen cycles. It fills the queue, sends part of it, and writes more until every write is an overwrite, and only then asserts a collision. It then checks that the replay fails and that a following frame end lets the next collision replay correctly. Randomised phases in both modes, with different levels and option settings, then mix collisions, frame ends, end-of-frame marks, overflows and underruns at random points.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
   localparam int FULL_DEPTH  = 96;
   localparam int SMALL_DEPTH = 32;
   localparam int SMALL_LEVEL = 16;
   localparam int BYTE_W      = 8;
endpackage

// File: rtl/byte_ring.sv
module byte_ring #(
   parameter int DEPTH = 96,
   parameter int DW    = 8,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [PW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/level_cfg.sv
module level_cfg #(
   parameter int DEPTH       = 96,
   parameter int SMALL_DEPTH = 32,
   parameter int SMALL_LEVEL = 16,
   parameter bit COMPAT_EN   = 1'b1,
   parameter int CW          = $clog2(DEPTH + 1)
) (
   input  logic          compat_mode,
   input  logic [CW-1:0] level_in,
   output logic [CW-1:0] cap,
   output logic [CW-1:0] level
);
   localparam logic [CW-1:0] CAP_BIG   = CW'(DEPTH);
   localparam logic [CW-1:0] CAP_SMALL = CW'(SMALL_DEPTH);
   localparam logic [CW-1:0] LVL_SMALL = CW'(SMALL_LEVEL);

   generate
      if (COMPAT_EN) begin : g_compat
         assign cap   = compat_mode ? CAP_SMALL : CAP_BIG;
         assign level = compat_mode ? LVL_SMALL : level_in;
      end else begin : g_plain
         logic unused_mode;
         assign unused_mode = compat_mode;
         assign cap   = CAP_BIG;
         assign level = level_in;
      end
   endgenerate
endmodule

// File: rtl/tx_lane.sv
module tx_lane #(
   parameter int DEPTH = 96,
   parameter int DW    = 8,
   parameter int CW    = $clog2(DEPTH + 1),
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cap,
   input  logic [CW-1:0] level,
   input  logic          delay_start,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   input  logic          coll,
   input  logic          frame_end,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          dreq,
   output logic          start_ok,
   output logic          ovf,
   output logic          unf,
   output logic          rewind_fail
);
   localparam int XW = CW + 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [CW-1:0] occ_q, sent_q, occ_n, sent_n;
   logic [PW-1:0] rptr_q, wptr_q, rptr_n;
   logic          lost_q, ovf_q, unf_q, fail_q;
   logic          full, empty, wr_do, rd_req, rd_do, ovr, lost_eff, rewind;
   logic [XW-1:0] span, rp_ext, rp_back;

   assign full     = occ_q >= cap;
   assign empty    = occ_q == '0;
   assign wr_do    = wr && !full;
   assign rd_req   = rd && !coll;
   assign rd_do    = rd_req && !empty;
   assign span     = XW'(occ_q) + XW'(sent_q);
   assign ovr      = wr_do && (span >= XW'(cap));
   assign lost_eff = lost_q || ovr;
   assign rewind   = coll && !lost_eff;

   assign rp_ext  = XW'(rptr_q);
   assign rp_back = (rp_ext >= XW'(sent_q)) ? rp_ext - XW'(sent_q)
                                            : rp_ext + XW'(DEPTH) - XW'(sent_q);

   always_comb begin
      occ_n = occ_q + CW'(wr_do) - CW'(rd_do) + (rewind ? sent_q : '0);
      if (frame_end || rewind) sent_n = '0;
      else                     sent_n = sent_q + CW'(rd_do) - CW'(ovr);
      if (rewind)     rptr_n = PW'(rp_back);
      else if (rd_do) rptr_n = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      else            rptr_n = rptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q  <= '0;
         sent_q <= '0;
         rptr_q <= '0;
         wptr_q <= '0;
         lost_q <= 1'b0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         occ_q  <= occ_n;
         sent_q <= sent_n;
         rptr_q <= rptr_n;
         if (wr_do) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
         lost_q <= frame_end ? 1'b0 : lost_eff;
         ovf_q  <= ovf_q | (wr && full);
         unf_q  <= unf_q | (rd_req && empty);
         fail_q <= coll && lost_eff;
      end
   end

   byte_ring #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) store_i (
      .clk(clk), .we(wr_do), .waddr(wptr_q), .wdata(wdata),
      .raddr(rptr_q), .rdata(rdata)
   );

   assign count       = occ_q;
   assign dreq        = occ_q < level;
   assign start_ok    = delay_start ? (occ_q >= level) : !empty;
   assign ovf         = ovf_q;
   assign unf         = unf_q;
   assign rewind_fail = fail_q;

   // R1
   tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= cap);
   // R1
   tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
   // R10
   tx_fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |-> $past(coll));
   // R6
   tx_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !rd && !coll) |=> $stable(rdata));
endmodule

// File: rtl/rx_lane.sv
module rx_lane #(
   parameter int DEPTH = 96,
   parameter int DW    = 8,
   parameter int CW    = $clog2(DEPTH + 1),
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cap,
   input  logic [CW-1:0] level,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          eof,
   input  logic          rd,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          dreq,
   output logic          ovf,
   output logic          unf
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [CW-1:0] occ_q, occ_n;
   logic [PW-1:0] rptr_q, wptr_q;
   logic          eof_q, ovf_q, unf_q, full, empty, wr_do, rd_do;

   assign full  = occ_q >= cap;
   assign empty = occ_q == '0;
   assign wr_do = wr && !full;
   assign rd_do = rd && !empty;
   assign occ_n = occ_q + CW'(wr_do) - CW'(rd_do);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q  <= '0;
         rptr_q <= '0;
         wptr_q <= '0;
         eof_q  <= 1'b0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         occ_q <= occ_n;
         if (wr_do) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
         if (rd_do) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
         eof_q <= (eof_q || eof) && (occ_n != '0);
         ovf_q <= ovf_q | (wr && full);
         unf_q <= unf_q | (rd && empty);
      end
   end

   byte_ring #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) store_i (
      .clk(clk), .we(wr_do), .waddr(wptr_q), .wdata(wdata),
      .raddr(rptr_q), .rdata(rdata)
   );

   assign count = occ_q;
   assign dreq  = (occ_q >= level) || eof_q;
   assign ovf   = ovf_q;
   assign unf   = unf_q;

   // R1
   rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= cap);
   // R7
   rx_unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_q |=> unf_q);
   // R4
   rx_eof_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eof_q) |-> empty);
endmodule

// File: rtl/dual_lane_fifo.sv
module dual_lane_fifo
   import fifo_pair_pkg::*;
#(
   parameter int DEPTH       = FULL_DEPTH,
   parameter int SMALL_DEPTH = fifo_pair_pkg::SMALL_DEPTH,
   parameter int SMALL_LEVEL = fifo_pair_pkg::SMALL_LEVEL,
   parameter int DW          = BYTE_W,
   parameter bit COMPAT_EN   = 1'b1,
   localparam int CW         = $clog2(DEPTH + 1),
   localparam int PW         = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          compat_mode,
   input  logic [CW-1:0] level_cfg,
   input  logic          delay_start,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_wdata,
   input  logic          tx_rd,
   input  logic          tx_collision,
   input  logic          tx_frame_end,
   output logic [DW-1:0] tx_rdata,
   output logic [CW-1:0] tx_count,
   output logic          tx_dreq,
   output logic          tx_start_ok,
   output logic          tx_overflow,
   output logic          tx_underrun,
   output logic          tx_rewind_fail,
   input  logic          rx_wr,
   input  logic [DW-1:0] rx_wdata,
   input  logic          rx_eof,
   input  logic          rx_rd,
   output logic [DW-1:0] rx_rdata,
   output logic [CW-1:0] rx_count,
   output logic          rx_dreq,
   output logic          rx_overflow,
   output logic          rx_underrun
);
   generate
      if (SMALL_DEPTH > DEPTH || SMALL_DEPTH < 1)
         $error("dual_lane_fifo: SMALL_DEPTH must lie in 1..DEPTH");
      if (SMALL_LEVEL > SMALL_DEPTH)
         $error("dual_lane_fifo: SMALL_LEVEL exceeds SMALL_DEPTH");
      if (DEPTH < 2 || DW < 1)
         $error("dual_lane_fifo: DEPTH must be at least 2 and DW at least 1");
   endgenerate

   logic [CW-1:0] cap, level;

   level_cfg #(.DEPTH(DEPTH), .SMALL_DEPTH(SMALL_DEPTH), .SMALL_LEVEL(SMALL_LEVEL),
               .COMPAT_EN(COMPAT_EN), .CW(CW)) cfg_i (
      .compat_mode(compat_mode), .level_in(level_cfg), .cap(cap), .level(level)
   );

   tx_lane #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .PW(PW)) tx_i (
      .clk(clk), .rst_n(rst_n), .cap(cap), .level(level), .delay_start(delay_start),
      .wr(tx_wr), .wdata(tx_wdata), .rd(tx_rd), .coll(tx_collision),
      .frame_end(tx_frame_end), .rdata(tx_rdata), .count(tx_count), .dreq(tx_dreq),
      .start_ok(tx_start_ok), .ovf(tx_overflow), .unf(tx_underrun),
      .rewind_fail(tx_rewind_fail)
   );

   rx_lane #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .PW(PW)) rx_i (
      .clk(clk), .rst_n(rst_n), .cap(cap), .level(level),
      .wr(rx_wr), .wdata(rx_wdata), .eof(rx_eof), .rd(rx_rd),
      .rdata(rx_rdata), .count(rx_count), .dreq(rx_dreq),
      .ovf(rx_overflow), .unf(rx_underrun)
   );
endmodule

// File: tb/dual_lane_fifo_tb.sv
module dual_lane_fifo_tb_top;
   localparam int D  = 96;
   localparam int SD = 32;
   localparam int SL = 16;
   localparam int CW = $clog2(D + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic compat_mode = 1'b0, delay_start = 1'b0;
   logic [CW-1:0] level_cfg = CW'(40);
   logic tx_wr = 0, tx_rd = 0, tx_collision = 0, tx_frame_end = 0;
   logic rx_wr = 0, rx_eof = 0, rx_rd = 0;
   logic [7:0] tx_wdata = 0, rx_wdata = 0;
   logic [7:0] tx_rdata, rx_rdata;
   logic [CW-1:0] tx_count, rx_count;
   logic tx_dreq, tx_start_ok, tx_overflow, tx_underrun, tx_rewind_fail;
   logic rx_dreq, rx_overflow, rx_underrun;

   always #5 clk = ~clk;

   dual_lane_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .level_cfg(level_cfg),
      .delay_start(delay_start), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd),
      .tx_collision(tx_collision), .tx_frame_end(tx_frame_end), .tx_rdata(tx_rdata),
      .tx_count(tx_count), .tx_dreq(tx_dreq), .tx_start_ok(tx_start_ok),
      .tx_overflow(tx_overflow), .tx_underrun(tx_underrun),
      .tx_rewind_fail(tx_rewind_fail), .rx_wr(rx_wr), .rx_wdata(rx_wdata),
      .rx_eof(rx_eof), .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_count(rx_count),
      .rx_dreq(rx_dreq), .rx_overflow(rx_overflow), .rx_underrun(rx_underrun)
   );

   // behavioural reference state
   byte unsigned txq[$], sentq[$], rxq[$];
   bit m_lost, m_tovf, m_tunf, m_fail, m_rovf, m_runf, m_eof;
   int vectors = 0, miscompares = 0;
   bit finished = 0;

   task automatic chk(string tag, int act, int exp);
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   function automatic int cur_cap();
      return compat_mode ? SD : D;
   endfunction
   function automatic int cur_lvl();
      return compat_mode ? SL : int'(level_cfg);
   endfunction

   task automatic compare_all();
      int lvl = cur_lvl();
      vectors++;
      chk("R1 tx_count", int'(tx_count), txq.size());
      chk("R1 rx_count", int'(rx_count), rxq.size());
      chk("R1 tx_overflow", tx_overflow, m_tovf);
      chk("R1 rx_overflow", rx_overflow, m_rovf);
      chk("R2/R3 tx_dreq", tx_dreq, txq.size() < lvl);
      chk("R2/R4 rx_dreq", rx_dreq, (rxq.size() >= lvl) || m_eof);
      chk("R5 tx_start_ok", tx_start_ok,
          delay_start ? (txq.size() >= lvl) : (txq.size() >= 1));
      if (txq.size() > 0) chk("R6/R8 tx_rdata", tx_rdata, txq[0]);
      if (rxq.size() > 0) chk("R6 rx_rdata", rx_rdata, rxq[0]);
      chk("R7 tx_underrun", tx_underrun, m_tunf);
      chk("R7 rx_underrun", rx_underrun, m_runf);
      chk("R10 tx_rewind_fail", tx_rewind_fail, m_fail);
   endtask

   task automatic model_step();
      int cap = cur_cap();
      bit full, wr_do, rd_req, rd_do, ovr, lost_eff, rew;
      // transmit side: R1 R7 R8 R9 R10
      full     = txq.size() >= cap;
      wr_do    = tx_wr && !full;
      rd_req   = tx_rd && !tx_collision;
      rd_do    = rd_req && (txq.size() > 0);
      ovr      = wr_do && (txq.size() + sentq.size() >= cap);
      lost_eff = m_lost || ovr;
      rew      = tx_collision && !lost_eff;
      if (tx_wr && full) m_tovf = 1;
      if (rd_req && txq.size() == 0) m_tunf = 1;
      m_fail = tx_collision && lost_eff;
      if (rd_do) sentq.push_back(txq.pop_front());
      if (ovr) void'(sentq.pop_front());
      if (rew) begin
         txq = {sentq, txq};
         sentq.delete();
      end
      if (wr_do) txq.push_back(tx_wdata);
      if (tx_frame_end) begin
         sentq.delete();
         m_lost = 0;
      end else m_lost = lost_eff;
      // receive side: R1 R4 R7
      full = rxq.size() >= cap;
      if (rx_wr && full) m_rovf = 1;
      if (rx_rd && rxq.size() == 0) m_runf = 1;
      if (rx_rd && rxq.size() > 0) void'(rxq.pop_front());
      if (rx_wr && !full) rxq.push_back(rx_wdata);
      m_eof = (m_eof || rx_eof) && (rxq.size() != 0);
   endtask

   task automatic step(bit tw, bit tr, bit tc, bit tf, bit rw, bit rr, bit re);
      @(negedge clk);
      compare_all();
      tx_wr = tw; tx_rd = tr; tx_collision = tc; tx_frame_end = tf;
      rx_wr = rw; rx_rd = rr; rx_eof = re;
      tx_wdata = 8'($urandom); rx_wdata = 8'($urandom);
      @(posedge clk);
      model_step();
   endtask

   function automatic bit pct(int p);
      return $urandom_range(99) < p;
   endfunction

   task automatic phase(int n, int pw, int pr, int pc, int pf, int rw, int rr, int re);
      for (int i = 0; i < n; i++)
         step(pct(pw), pct(pr), pct(pc), pct(pf), pct(rw), pct(rr), pct(re));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R11 reset state
      @(negedge clk);
      vectors++;
      chk("R11 tx_count", int'(tx_count), 0);
      chk("R11 rx_count", int'(rx_count), 0);
      chk("R11 flags", {tx_overflow, tx_underrun, rx_overflow, rx_underrun, tx_rewind_fail}, 0);
      chk("R11 rx_dreq", rx_dreq, 0);
      chk("R11 tx_dreq", tx_dreq, 1);

      // R8: fill 10, send 6, collide, resend all 10 in order
      for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++)  step(0, 1, 0, 0, 0, 0, 0);
      step(0, 1, 1, 0, 0, 0, 0);
      for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, 0, 0);
      // R9: frame end then a collision replays nothing
      step(0, 0, 0, 1, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);

      // R10 in compat mode: fill, partial send, refill over sent bytes, collide
      compat_mode = 1'b1;
      for (int i = 0; i < 32; i++) step(1, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 0, 0, 0);
      for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      phase(40, 0, 100, 0, 0, 0, 0, 0);

      // R4: receive end of frame below level
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1);
      phase(5, 0, 0, 0, 0, 0, 100, 0);

      // R5 delayed start, random mixes in compat mode
      delay_start = 1'b1;
      phase(600, 55, 45, 4, 3, 55, 45, 5);
      phase(80, 0, 100, 0, 0, 0, 100, 0);
      step(0, 0, 0, 1, 0, 0, 0);

      // normal mode with several levels
      compat_mode = 1'b0;
      level_cfg = CW'(90);
      phase(600, 70, 30, 3, 2, 70, 30, 3);
      delay_start = 1'b0;
      level_cfg = CW'(1);
      phase(600, 45, 55, 5, 4, 45, 55, 5);
      level_cfg = CW'(40);
      phase(800, 60, 40, 6, 1, 60, 40, 4);
      phase(300, 20, 80, 3, 5, 20, 80, 2);
      @(negedge clk);
      compare_all();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(10 * 200000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual run unfinished, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule